// File: doc/BRIEF.md
# Checkpointed Register Rename Map Table

This block holds the speculative mapping from each of the 32 architectural registers to a physical register in an out-of-order core. Each cycle it takes up to two instructions in program order, the rename group. For each lane it returns the physical registers of both sources and the physical register that currently backs the destination, which is the stale destination. The physical register to install comes from an allocator outside the block. The new mappings take effect at the next clock edge. Register specifiers sit at fixed bit positions in the raw instruction word, so lookup starts before the instruction is fully decoded.

On a branch the map is saved into a checkpoint slot chosen by a tag, and a later mispredict on that tag restores the whole map in one cycle. A second map, written only by committing instructions, holds the architectural state. On a flush or exception the speculative map is reloaded from it in one cycle, so the reorder buffer is never walked back. Rename stalls while every checkpoint slot is in use.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset both maps and every checkpoint map architectural register i to physical register i, no slot is in use, `ckpt_full_o` is 0 and `ren_ready_o` is 1.
- R2: Per lane the specifiers are read from fixed bit fields of the instruction word: first source at [19:15], second source at [24:20], destination at [11:7]. The looked-up physical registers appear on the outputs in the same cycle.
- R3: `ren_stale_o` is the mapping of the lane's destination before the group's writes. A lane that is valid, has `ren_wr_i` set and a nonzero destination installs `ren_pdst_i` at the next edge. Invalid lanes and lanes without a write change nothing.
- R4: Within a group, a lane's sources and stale destination see the new mapping of any earlier writing lane with the same register. When two lanes write the same register, the higher lane's mapping is kept.
- R5: Architectural register 0 always reads physical register 0. Renames and commits that target register 0 are ignored.
- R6: An accepted `ckpt_save_i` stores into slot `ckpt_tag_i` the map as it stands after that cycle's renames, and marks the slot in use.
- R7: `mispred_i` reloads the whole speculative map from slot `mispred_tag_i` at the next edge and releases that slot. `ren_ready_o` is 0 in that cycle, so the same-cycle rename and save are dropped.
- R8: `ckpt_full_o` is 1 while all slots are in use. In that state `ren_ready_o` is 0 and renames and saves are dropped. `ckpt_free_i` releases slot `ckpt_free_tag_i`.
- R9: Each valid commit lane writes `cmt_preg_i` for `cmt_areg_i` into the committed map, with the higher lane winning, and leaves the speculative map unchanged. `flush_i` copies the committed map into the speculative map at the next edge, releases all slots and holds `ren_ready_o` at 0 for that cycle.
- R10: When `flush_i` and `mispred_i` are both set, the flush decides the restored map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | LANES | Lane holds an instruction |
| ren_insn_i | input | LANES x 32 | Raw instruction word per lane |
| ren_wr_i | input | LANES | Lane writes a destination register |
| ren_pdst_i | input | LANES x PW | Newly allocated physical destination |
| ren_psrc1_o | output | LANES x PW | Physical first source |
| ren_psrc2_o | output | LANES x PW | Physical second source |
| ren_stale_o | output | LANES x PW | Previous physical destination |
| ren_ready_o | output | 1 | Group is accepted this cycle |
| ckpt_save_i | input | 1 | Save the map for a branch |
| ckpt_tag_i | input | TW | Slot to save into |
| ckpt_free_i | input | 1 | Release a resolved branch's slot |
| ckpt_free_tag_i | input | TW | Slot to release |
| ckpt_full_o | output | 1 | All slots in use |
| mispred_i | input | 1 | Restore from a checkpoint |
| mispred_tag_i | input | TW | Slot to restore from |
| flush_i | input | 1 | Reload the committed map |
| cmt_valid_i | input | LANES | Commit lane valid |
| cmt_areg_i | input | LANES x 5 | Committed architectural register |
| cmt_preg_i | input | LANES x PW | Committed physical register |

## Verification
Restore and rename can fall in the same cycle: the bench saves a checkpoint together with a rename, renames further, and then raises a mispredict while a lane tries to rename another register. It judges the outcome by checking that `ren_ready_o` is low in that cycle and that, afterwards, the checkpoint contents come back while the dropped destination still reads its old mapping. Flush and mispredict are raised together in the same way, and the bench checks that the committed mapping wins over the checkpoint.

// File: rtl/rmt_pkg.sv
`timescale 1ns/1ps
package rmt_pkg;
  localparam int ARCH_REGS = 32;
  localparam int AREG_W    = 5;
  localparam int INSN_W    = 32;
  localparam int DST_LSB   = 7;
  localparam int SRC1_LSB  = 15;
  localparam int SRC2_LSB  = 20;
endpackage

// File: rtl/rmt_group.sv
`timescale 1ns/1ps
module rmt_group
  import rmt_pkg::*;
#(
  parameter int LANES = 2,
  parameter int PW    = 6
) (
  input  logic [ARCH_REGS-1:0][PW-1:0] map_i,
  input  logic [LANES-1:0]             valid_i,
  input  logic [LANES-1:0][INSN_W-1:0] insn_i,
  input  logic [LANES-1:0]             wr_i,
  input  logic [LANES-1:0][PW-1:0]     pdst_i,
  output logic [LANES-1:0][PW-1:0]     psrc1_o,
  output logic [LANES-1:0][PW-1:0]     psrc2_o,
  output logic [LANES-1:0][PW-1:0]     stale_o,
  output logic [ARCH_REGS-1:0][PW-1:0] next_map_o
);
  logic [LANES-1:0][AREG_W-1:0] dst, src1, src2;
  logic [LANES-1:0]             we;

  for (genvar k = 0; k < LANES; k++) begin : g_fld
    assign dst[k]  = insn_i[k][DST_LSB  +: AREG_W];
    assign src1[k] = insn_i[k][SRC1_LSB +: AREG_W];
    assign src2[k] = insn_i[k][SRC2_LSB +: AREG_W];
    assign we[k]   = valid_i[k] && wr_i[k] && (dst[k] != '0);
  end

  // older lanes forward in order, so the youngest earlier writer wins
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      psrc1_o[k] = map_i[src1[k]];
      psrc2_o[k] = map_i[src2[k]];
      stale_o[k] = map_i[dst[k]];
      for (int j = 0; j < LANES; j++) begin
        if (j < k && we[j]) begin
          if (dst[j] == src1[k]) psrc1_o[k] = pdst_i[j];
          if (dst[j] == src2[k]) psrc2_o[k] = pdst_i[j];
          if (dst[j] == dst[k])  stale_o[k] = pdst_i[j];
        end
      end
    end
  end

  always_comb begin
    next_map_o = map_i;
    for (int k = 0; k < LANES; k++)
      if (we[k]) next_map_o[dst[k]] = pdst_i[k];
  end
endmodule

// File: rtl/rmt_ckpt_store.sv
`timescale 1ns/1ps
module rmt_ckpt_store
  import rmt_pkg::*;
#(
  parameter int NUM_CKPT = 4,
  parameter int PW       = 6,
  localparam int TW      = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         save_i,
  input  logic [TW-1:0]                save_tag_i,
  input  logic [ARCH_REGS-1:0][PW-1:0] save_map_i,
  input  logic                         free_i,
  input  logic [TW-1:0]                free_tag_i,
  input  logic                         restore_i,
  input  logic [TW-1:0]                restore_tag_i,
  input  logic                         clear_i,
  output logic [ARCH_REGS-1:0][PW-1:0] rd_map_o,
  output logic                         full_o
);
  logic [NUM_CKPT-1:0][ARCH_REGS-1:0][PW-1:0] slot_q;
  logic [NUM_CKPT-1:0]                        busy_q, busy_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_CKPT; s++)
        for (int i = 0; i < ARCH_REGS; i++)
          slot_q[s][i] <= PW'(i);
    end else if (save_i) begin
      slot_q[save_tag_i] <= save_map_i;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (free_i)    busy_d[free_tag_i]    = 1'b0;
    if (restore_i) busy_d[restore_tag_i] = 1'b0;
    if (save_i)    busy_d[save_tag_i]    = 1'b1;
    if (clear_i)   busy_d                = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end

  assign rd_map_o = slot_q[restore_tag_i];
  assign full_o   = &busy_q;

  a_r6_save_marks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !clear_i) |=> busy_q[$past(save_tag_i)]);
  a_r6_save_stores_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> slot_q[$past(save_tag_i)] == $past(save_map_i));
  a_r9_flush_clears_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> busy_q == '0);
  a_r8_no_save_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !save_i);
endmodule

// File: rtl/rmt_commit_map.sv
`timescale 1ns/1ps
module rmt_commit_map
  import rmt_pkg::*;
#(
  parameter int LANES = 2,
  parameter int PW    = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             valid_i,
  input  logic [LANES-1:0][AREG_W-1:0] areg_i,
  input  logic [LANES-1:0][PW-1:0]     preg_i,
  output logic [ARCH_REGS-1:0][PW-1:0] map_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) map_o[i] <= PW'(i);
    end else begin
      for (int k = 0; k < LANES; k++)
        if (valid_i[k] && areg_i[k] != '0) map_o[areg_i[k]] <= preg_i[k];
    end
  end

  a_r5_commit_zero_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_o[0] == '0);
endmodule

// File: rtl/rename_map_ckpt.sv
`timescale 1ns/1ps
module rename_map_ckpt
  import rmt_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int PHYS_REGS = 64,
  parameter int NUM_CKPT  = 4,
  localparam int PW       = $clog2(PHYS_REGS),
  localparam int TW       = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             ren_valid_i,
  input  logic [LANES-1:0][INSN_W-1:0] ren_insn_i,
  input  logic [LANES-1:0]             ren_wr_i,
  input  logic [LANES-1:0][PW-1:0]     ren_pdst_i,
  output logic [LANES-1:0][PW-1:0]     ren_psrc1_o,
  output logic [LANES-1:0][PW-1:0]     ren_psrc2_o,
  output logic [LANES-1:0][PW-1:0]     ren_stale_o,
  output logic                         ren_ready_o,
  input  logic                         ckpt_save_i,
  input  logic [TW-1:0]                ckpt_tag_i,
  input  logic                         ckpt_free_i,
  input  logic [TW-1:0]                ckpt_free_tag_i,
  output logic                         ckpt_full_o,
  input  logic                         mispred_i,
  input  logic [TW-1:0]                mispred_tag_i,
  input  logic                         flush_i,
  input  logic [LANES-1:0]             cmt_valid_i,
  input  logic [LANES-1:0][AREG_W-1:0] cmt_areg_i,
  input  logic [LANES-1:0][PW-1:0]     cmt_preg_i
);
  logic [ARCH_REGS-1:0][PW-1:0] spec_q, next_map, ckpt_map, cmt_map;
  logic save_go, restore_go;

  assign ren_ready_o = !flush_i && !mispred_i && !ckpt_full_o;
  assign save_go     = ckpt_save_i && ren_ready_o;
  assign restore_go  = mispred_i && !flush_i;

  rmt_group #(.LANES(LANES), .PW(PW)) u_group (
    .map_i      (spec_q),
    .valid_i    (ren_valid_i),
    .insn_i     (ren_insn_i),
    .wr_i       (ren_wr_i),
    .pdst_i     (ren_pdst_i),
    .psrc1_o    (ren_psrc1_o),
    .psrc2_o    (ren_psrc2_o),
    .stale_o    (ren_stale_o),
    .next_map_o (next_map)
  );

  rmt_ckpt_store #(.NUM_CKPT(NUM_CKPT), .PW(PW)) u_ckpt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .save_i        (save_go),
    .save_tag_i    (ckpt_tag_i),
    .save_map_i    (next_map),
    .free_i        (ckpt_free_i),
    .free_tag_i    (ckpt_free_tag_i),
    .restore_i     (restore_go),
    .restore_tag_i (mispred_tag_i),
    .clear_i       (flush_i),
    .rd_map_o      (ckpt_map),
    .full_o        (ckpt_full_o)
  );

  rmt_commit_map #(.LANES(LANES), .PW(PW)) u_cmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cmt_valid_i),
    .areg_i  (cmt_areg_i),
    .preg_i  (cmt_preg_i),
    .map_o   (cmt_map)
  );

  // flush over mispredict over rename
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) spec_q[i] <= PW'(i);
    end else if (flush_i) begin
      spec_q <= cmt_map;
    end else if (mispred_i) begin
      spec_q <= ckpt_map;
    end else if (ren_ready_o) begin
      spec_q <= next_map;
    end
  end

  a_r5_zero_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_q[0] == '0);
  a_r7_restore_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_go |=> spec_q == $past(ckpt_map));
  a_r9_flush_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> spec_q == $past(cmt_map));
  a_r8_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ckpt_full_o && !flush_i && !mispred_i) |=> $stable(spec_q));
  a_r7_drop_rename: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_i |-> !ren_ready_o);
endmodule

// File: tb/sim_rename_map_ckpt.sv
`timescale 1ns/1ps
module sim_rename_map_ckpt;
  localparam int LANES = 2;
  localparam int PW    = 6;
  localparam int TW    = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [LANES-1:0]          ren_valid, ren_wr;
  logic [LANES-1:0][31:0]    ren_insn;
  logic [LANES-1:0][PW-1:0]  ren_pdst, psrc1, psrc2, stale;
  logic                      ready, full;
  logic                      save, free_b, mispred, flush;
  logic [TW-1:0]             tag, free_tag, mp_tag;
  logic [LANES-1:0]          cmt_valid;
  logic [LANES-1:0][4:0]     cmt_areg;
  logic [LANES-1:0][PW-1:0]  cmt_preg;

  rename_map_ckpt u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid), .ren_insn_i(ren_insn), .ren_wr_i(ren_wr),
    .ren_pdst_i(ren_pdst), .ren_psrc1_o(psrc1), .ren_psrc2_o(psrc2),
    .ren_stale_o(stale), .ren_ready_o(ready),
    .ckpt_save_i(save), .ckpt_tag_i(tag), .ckpt_free_i(free_b),
    .ckpt_free_tag_i(free_tag), .ckpt_full_o(full),
    .mispred_i(mispred), .mispred_tag_i(mp_tag), .flush_i(flush),
    .cmt_valid_i(cmt_valid), .cmt_areg_i(cmt_areg), .cmt_preg_i(cmt_preg)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // per row: v,rd,rs1,rs2,wr,pd for lane0 then lane1; expected s1,s2,stale lane0 then lane1
  localparam int ROWS = 6;
  localparam int TBL [ROWS][18] = '{
    '{1,1,2,3,1,40,  1,4,1,5,1,41,   2,3,1,   40,5,4},
    '{1,1,1,4,1,42,  1,1,1,0,1,43,   40,41,40, 42,0,42},
    '{1,0,1,0,1,44,  1,6,0,1,1,45,   43,0,0,  0,43,6},
    '{1,2,6,7,0,50,  1,7,2,6,1,46,   45,7,2,  2,45,7},
    '{0,3,3,3,1,50,  1,3,7,3,1,47,   3,3,3,   46,3,3},
    '{1,1,1,7,0,0,   1,4,3,4,0,0,    43,46,43, 47,41,41}
  };

  function automatic logic [31:0] mk(input int rd, input int a, input int b);
    return {7'd0, 5'(b), 5'(a), 3'd0, 5'(rd), 7'b0110011};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = '0; ren_wr = '0; ren_insn = '0; ren_pdst = '0;
    save = 0; tag = '0; free_b = 0; free_tag = '0;
    mispred = 0; mp_tag = '0; flush = 0;
    cmt_valid = '0; cmt_areg = '0; cmt_preg = '0;
  endtask

  task automatic lane(input int k, input int v, input int rd, input int a,
                      input int b, input int w, input int pd);
    ren_valid[k] = 1'(v);
    ren_insn[k]  = mk(rd, a, b);
    ren_wr[k]    = 1'(w);
    ren_pdst[k]  = PW'(pd);
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 field positions
    lane(0, 0, 12, 5, 9, 0, 0);
    lane(1, 0, 31, 30, 17, 0, 0);
    #1;
    chk("R1 ready", int'(ready), 1);
    chk("R1 full", int'(full), 0);
    chk("R2 src1 l0", int'(psrc1[0]), 5);
    chk("R2 src2 l0", int'(psrc2[0]), 9);
    chk("R2 stale l0", int'(stale[0]), 12);
    chk("R1 src1 l1", int'(psrc1[1]), 30);
    chk("R1 stale l1", int'(stale[1]), 31);
    step();

    // R3 R4 R5 table walk
    for (int r = 0; r < ROWS; r++) begin
      lane(0, TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], TBL[r][5]);
      lane(1, TBL[r][6], TBL[r][7], TBL[r][8], TBL[r][9], TBL[r][10], TBL[r][11]);
      #1;
      chk($sformatf("R3/R4 row%0d s1 l0", r), int'(psrc1[0]), TBL[r][12]);
      chk($sformatf("R3/R4 row%0d s2 l0", r), int'(psrc2[0]), TBL[r][13]);
      chk($sformatf("R3/R5 row%0d st l0", r), int'(stale[0]), TBL[r][14]);
      chk($sformatf("R4 row%0d s1 l1", r), int'(psrc1[1]), TBL[r][15]);
      chk($sformatf("R4 row%0d s2 l1", r), int'(psrc2[1]), TBL[r][16]);
      chk($sformatf("R4 row%0d st l1", r), int'(stale[1]), TBL[r][17]);
      step();
    end

    // R6 save with same-cycle rename, then R7 restore vs rename
    save = 1; tag = 2'd2;
    lane(0, 1, 1, 0, 0, 1, 50);
    #1 chk("R6 ready on save", int'(ready), 1);
    step();
    lane(0, 1, 1, 0, 0, 1, 51);
    lane(1, 1, 8, 0, 0, 1, 52);
    step();
    mispred = 1; mp_tag = 2'd2;
    lane(0, 1, 9, 0, 0, 1, 53);
    #1 chk("R7 ready low on restore", int'(ready), 0);
    step();
    lane(0, 0, 9, 1, 8, 0, 0);
    #1;
    chk("R6 R7 restored r1", int'(psrc1[0]), 50);
    chk("R7 r8 rolled back", int'(psrc2[0]), 8);
    chk("R7 dropped rename r9", int'(stale[0]), 9);
    chk("R7 slot released", int'(full), 0);
    step();

    // R8 fill all slots
    for (int s = 0; s < 4; s++) begin
      save = 1; tag = TW'(s);
      step();
    end
    #1;
    chk("R8 full", int'(full), 1);
    chk("R8 ready low", int'(ready), 0);
    step();
    lane(0, 1, 10, 0, 0, 1, 60);
    save = 1; tag = 2'd1;
    step();
    lane(0, 0, 0, 10, 0, 0, 0);
    #1 chk("R8 stalled rename ignored", int'(psrc1[0]), 10);
    step();
    free_b = 1; free_tag = 2'd1;
    step();
    #1;
    chk("R8 free releases", int'(full), 0);
    chk("R8 ready back", int'(ready), 1);
    step();

    // R9 commits and flush
    cmt_valid = 2'b11; cmt_areg[0] = 5'd5; cmt_preg[0] = 6'd30;
    cmt_areg[1] = 5'd5; cmt_preg[1] = 6'd31;
    step();
    cmt_valid = 2'b11; cmt_areg[0] = 5'd0; cmt_preg[0] = 6'd33;
    cmt_areg[1] = 5'd11; cmt_preg[1] = 6'd34;
    step();
    lane(0, 0, 0, 5, 0, 0, 0);
    #1 chk("R9 commit leaves spec", int'(psrc1[0]), 5);
    step();
    save = 1; tag = 2'd0;
    step();
    flush = 1;
    #1 chk("R9 ready low on flush", int'(ready), 0);
    step();
    lane(0, 0, 11, 5, 1, 0, 0);
    lane(1, 0, 0, 0, 3, 0, 0);
    #1;
    chk("R9 higher commit lane wins", int'(psrc1[0]), 31);
    chk("R9 spec r1 reverted", int'(psrc2[0]), 1);
    chk("R9 r11 committed", int'(stale[0]), 34);
    chk("R5 commit to r0 ignored", int'(psrc1[1]), 0);
    chk("R9 r3 reverted", int'(psrc2[1]), 3);
    chk("R9 slots cleared", int'(full), 0);
    step();

    // R10 flush and mispredict together
    save = 1; tag = 2'd0;
    lane(0, 1, 2, 0, 0, 1, 61);
    step();
    lane(0, 1, 2, 0, 0, 1, 62);
    step();
    flush = 1; mispred = 1; mp_tag = 2'd0;
    step();
    lane(0, 0, 0, 2, 0, 0, 0);
    #1 chk("R10 flush beats restore", int'(psrc1[0]), 2);
    step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule